// File: doc/BRIEF.md
# USB Endpoint Control and Status Register

This block holds the control and status word of one USB device endpoint and decides the handshake for every token the serial interface engine forwards to that endpoint. The engine reports decoded events as one-cycle pulses: a valid SETUP stored, OUT data stored, an IN or OUT token seen, and a host ACK received after the endpoint sent data. For each token the block answers one cycle later with ACK, NAK, STALL, a data packet, or a zero-length packet.

On a control endpoint the block also tracks the phase of a control transfer. A received SETUP wipes the word. Firmware sets the direction bit, loads packets, and raises the last-data bit to move the endpoint into the status stage. While the status stage is pending, processor writes are ignored. When the status stage ends, the last-data bit stays set, and firmware clears it later. A non-control endpoint (`IS_CONTROL = 0`) runs the same logic. On such an endpoint the control-only bits read as zero and have no effect.

The token path has no ready signal. USB turnaround timing leaves no room for back-pressure, so every token pulse is answered by exactly one handshake pulse on the next cycle. The processor side is a plain write strobe with a read-back of the whole word. The interrupt output is a level: it is the OR of the status sources after masking.

Top module: `usb_ep_csr`

## Requirements
- R1: After reset the status word reads 0, `hs_valid` is 0, and with a zero mask `irq` is 0.
- R2: The word has these fields: bit0 tx_done, bit1 out_full, bit2 setup_seen, bit3 stalled, bit4 last_data, bit5 stall_req, bit6 in_ready, bit7 wr_en, bit8 dir_in (1 means a control read).
  - Bits 4 to 8 take the value written to them.
  - Bits 0 to 3 are cleared by writing 0 to them, and writing 1 leaves them unchanged.
  - A write is visible on `bus_rdata` in the cycle after the strobe.
- R3: When hardware sets a bit in the same cycle that a write clears it, the bit ends up set.
- R4: On a control endpoint, `ev_setup` makes the word read exactly 0x004 in the next cycle. This holds even when a processor write falls in the same cycle.
- R5: Handshake codes are ACK=0, NAK=1, STALL=2, DATA=3 and ZLP=4.
  - An OUT token is answered NAK while out_full is set.
  - On a control endpoint, an OUT token is also answered NAK while setup_seen is set, or while wr_en is clear outside the status stage.
  - Otherwise an OUT token is answered ACK.
  - `ev_out_ok` sets out_full.
- R6: An IN token is answered DATA when in_ready is set and NAK when it is clear. `ev_ack` clears in_ready.
- R7: While stall_req is set, every token is answered STALL, and stalled becomes set in the same cycle as the handshake.
- R8: A write that raises last_data on a control endpoint starts the status stage.
  - If that write also sets in_ready, the stage starts after the last packet is ACKed. Otherwise it starts at once.
  - Until the stage completes, every processor write is ignored.
- R9: Control read (dir_in=1):
  - The ACK of the packet sent with last_data set also sets tx_done.
  - The status OUT is then answered ACK without regard to wr_en.
  - Its `ev_out_ok` sets out_full, ends the stage, leaves last_data set, and makes the word writable again.
- R10: Control write or no data stage (dir_in=0):
  - In the status stage an IN token is answered ZLP.
  - The ACK of that ZLP sets tx_done, ends the stage, and leaves last_data set.
- R11: Mask bits `irq_en` are [0] tx_done, [1] out_full, [2] setup_seen, [3] stalled and [4] in_ready clear. `irq` is the OR of the sources whose mask bit is set.
- R12: On a non-control endpoint:
  - Bits 2, 4, 7 and 8 read 0.
  - `ev_setup` has no effect.
  - An OUT token is answered ACK without wr_en.
  - A write that raises last_data does not lock later writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Processor write strobe, one cycle |
| bus_wdata | input | 9 | Processor write data |
| bus_rdata | output | 9 | Current status word |
| irq_en | input | 5 | Interrupt source mask |
| irq | output | 1 | Masked interrupt, level |
| tok_valid | input | 1 | Token for this endpoint, one cycle |
| tok_in | input | 1 | 1 for IN token, 0 for OUT token |
| ev_setup | input | 1 | Valid SETUP packet stored |
| ev_out_ok | input | 1 | OUT data packet stored |
| ev_ack | input | 1 | Host ACKed the packet this endpoint sent |
| hs_valid | output | 1 | Handshake decision valid, one cycle after the token |
| hs_code | output | 3 | Handshake decision code |

## Verification
Two kinds of same-cycle collision matter here. The first is a firmware write that clears a hardware-owned bit in the cycle that hardware sets it. The bench provokes this by pulsing `ev_out_ok` together with a write of 0 and expects out_full to survive. The second is a SETUP that arrives together with a processor write carrying other bits. The bench fires both in one cycle and expects the word to read exactly 0x004, showing that the SETUP wipe overrides the write. During a pending status stage the bench also issues writes and checks that the word is unchanged on read-back.

// File: rtl/usb_ep_csr_pkg.sv
package usb_ep_csr_pkg;
  localparam int CSR_W = 9;
  localparam int IRQ_W = 5;
  localparam int HS_W  = 3;

  localparam int B_TXDONE  = 0;
  localparam int B_OUTFULL = 1;
  localparam int B_SETUP   = 2;
  localparam int B_STALLED = 3;
  localparam int B_LAST    = 4;
  localparam int B_STALLRQ = 5;
  localparam int B_INRDY   = 6;
  localparam int B_WREN    = 7;
  localparam int B_DIRIN   = 8;

  localparam logic [CSR_W-1:0] HW_MASK   = (CSR_W)'(1 << B_TXDONE) | (CSR_W)'(1 << B_OUTFULL)
                                         | (CSR_W)'(1 << B_SETUP)  | (CSR_W)'(1 << B_STALLED);
  localparam logic [CSR_W-1:0] CTRL_MASK = (CSR_W)'(1 << B_SETUP)  | (CSR_W)'(1 << B_LAST)
                                         | (CSR_W)'(1 << B_WREN)   | (CSR_W)'(1 << B_DIRIN);
  localparam logic [CSR_W-1:0] SETUP_WORD = (CSR_W)'(1 << B_SETUP);

  typedef enum logic [HS_W-1:0] {
    HS_ACK   = 3'd0,
    HS_NAK   = 3'd1,
    HS_STALL = 3'd2,
    HS_DATA  = 3'd3,
    HS_ZLP   = 3'd4
  } hs_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_LAST   = 2'd1,
    PH_STATUS = 2'd2
  } phase_e;
endpackage

// File: rtl/ep_csr_regs.sv
module ep_csr_regs
  import usb_ep_csr_pkg::*;
#(
  parameter bit IS_CONTROL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ok,
  input  logic [CSR_W-1:0] wdata,
  input  logic             setup_hit,
  input  logic             set_out_full,
  input  logic             set_tx_done,
  input  logic             set_stalled,
  input  logic             clr_in_ready,
  output logic [CSR_W-1:0] csr
);
  logic [CSR_W-1:0] nxt;

  always_comb begin
    nxt = csr;
    // software bits follow the write, hardware bits only clear on a 0
    if (wr_ok) nxt = (wdata & ~HW_MASK) | (csr & wdata & HW_MASK);
    // hardware sets are applied after the write so they win
    if (set_out_full) nxt[B_OUTFULL] = 1'b1;
    if (set_tx_done)  nxt[B_TXDONE]  = 1'b1;
    if (set_stalled)  nxt[B_STALLED] = 1'b1;
    if (clr_in_ready) nxt[B_INRDY]   = 1'b0;
    if (!IS_CONTROL)  nxt = nxt & ~CTRL_MASK;
    if (setup_hit)    nxt = SETUP_WORD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) csr <= '0;
    else        csr <= nxt;
  end
endmodule

// File: rtl/ep_phase_fsm.sv
module ep_phase_fsm
  import usb_ep_csr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   setup_hit,
  input  logic   last_rise,
  input  logic   last_with_data,
  input  logic   dir_in,
  input  logic   ev_ack,
  input  logic   ev_out_ok,
  output phase_e phase,
  output logic   set_tx_done
);
  phase_e phase_nxt;

  always_comb begin
    phase_nxt = phase;
    if (setup_hit) begin
      phase_nxt = PH_IDLE;
    end else begin
      unique case (phase)
        PH_IDLE:   if (last_rise) phase_nxt = last_with_data ? PH_LAST : PH_STATUS;
        PH_LAST:   if (ev_ack) phase_nxt = PH_STATUS;
        PH_STATUS: begin
          if (dir_in && ev_out_ok)  phase_nxt = PH_IDLE;
          if (!dir_in && ev_ack)    phase_nxt = PH_IDLE;
        end
        default:   phase_nxt = PH_IDLE;
      endcase
    end
  end

  assign set_tx_done = !setup_hit && ev_ack &&
                       ((phase == PH_LAST && dir_in) || (phase == PH_STATUS && !dir_in));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_nxt;
  end
endmodule

// File: rtl/ep_hs_decide.sv
module ep_hs_decide
  import usb_ep_csr_pkg::*;
#(
  parameter bit IS_CONTROL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tok_valid,
  input  logic             tok_in,
  input  logic [CSR_W-1:0] csr,
  input  phase_e           phase,
  output logic             stall_now,
  output logic             hs_valid,
  output hs_e              hs_code
);
  hs_e    pick;
  logic   in_status;

  assign in_status = IS_CONTROL && (phase == PH_STATUS);
  assign stall_now = tok_valid && csr[B_STALLRQ];

  always_comb begin
    pick = HS_NAK;
    if (csr[B_STALLRQ]) begin
      pick = HS_STALL;
    end else if (tok_in) begin
      if (in_status)          pick = csr[B_DIRIN] ? HS_NAK : HS_ZLP;
      else if (csr[B_INRDY])  pick = HS_DATA;
      else                    pick = HS_NAK;
    end else begin
      if (csr[B_OUTFULL])                              pick = HS_NAK;
      else if (!IS_CONTROL)                            pick = HS_ACK;
      else if (csr[B_SETUP])                           pick = HS_NAK;
      else if (in_status)                              pick = csr[B_DIRIN] ? HS_ACK : HS_NAK;
      else if (phase != PH_IDLE || !csr[B_WREN])       pick = HS_NAK;
      else                                             pick = HS_ACK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_valid <= 1'b0;
      hs_code  <= HS_ACK;
    end else begin
      hs_valid <= tok_valid;
      if (tok_valid) hs_code <= pick;
    end
  end
endmodule

// File: rtl/usb_ep_csr.sv
module usb_ep_csr
  import usb_ep_csr_pkg::*;
#(
  parameter bit IS_CONTROL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [CSR_W-1:0] bus_wdata,
  output logic [CSR_W-1:0] bus_rdata,
  input  logic [IRQ_W-1:0] irq_en,
  output logic             irq,
  input  logic             tok_valid,
  input  logic             tok_in,
  input  logic             ev_setup,
  input  logic             ev_out_ok,
  input  logic             ev_ack,
  output logic             hs_valid,
  output logic [HS_W-1:0]  hs_code
);
  logic [CSR_W-1:0] csr;
  phase_e           phase;
  logic             locked;
  logic             wr_ok;
  logic             setup_hit;
  logic             set_tx_done;
  logic             stall_now;
  hs_e              hs_pick;
  logic [IRQ_W-1:0] irq_src;

  assign locked    = (phase != PH_IDLE);
  assign wr_ok     = bus_wr && !locked;
  assign setup_hit = IS_CONTROL && ev_setup;

  generate
    if (IS_CONTROL) begin : g_ctrl
      logic last_rise;
      assign last_rise = wr_ok && bus_wdata[B_LAST] && !csr[B_LAST];
      ep_phase_fsm u_phase (
        .clk            (clk),
        .rst_n          (rst_n),
        .setup_hit      (setup_hit),
        .last_rise      (last_rise),
        .last_with_data (bus_wdata[B_INRDY]),
        .dir_in         (csr[B_DIRIN]),
        .ev_ack         (ev_ack),
        .ev_out_ok      (ev_out_ok),
        .phase          (phase),
        .set_tx_done    (set_tx_done)
      );
    end else begin : g_plain
      assign phase       = PH_IDLE;
      assign set_tx_done = 1'b0;
    end
  endgenerate

  ep_csr_regs #(.IS_CONTROL(IS_CONTROL)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_ok        (wr_ok),
    .wdata        (bus_wdata),
    .setup_hit    (setup_hit),
    .set_out_full (ev_out_ok),
    .set_tx_done  (set_tx_done),
    .set_stalled  (stall_now),
    .clr_in_ready (ev_ack),
    .csr          (csr)
  );

  ep_hs_decide #(.IS_CONTROL(IS_CONTROL)) u_hs (
    .clk       (clk),
    .rst_n     (rst_n),
    .tok_valid (tok_valid),
    .tok_in    (tok_in),
    .csr       (csr),
    .phase     (phase),
    .stall_now (stall_now),
    .hs_valid  (hs_valid),
    .hs_code   (hs_pick)
  );

  assign hs_code   = hs_pick;
  assign bus_rdata = csr;
  assign irq_src   = {~csr[B_INRDY], csr[B_STALLED], csr[B_SETUP], csr[B_OUTFULL], csr[B_TXDONE]};
  assign irq       = |(irq_src & irq_en);
endmodule

// File: rtl/usb_ep_csr_chk.sv
module usb_ep_csr_chk
  import usb_ep_csr_pkg::*;
#(
  parameter bit IS_CONTROL = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic             tok_valid,
  input logic             tok_in,
  input logic             ev_setup,
  input logic             ev_out_ok,
  input logic             ev_ack,
  input logic [CSR_W-1:0] bus_rdata,
  input logic             hs_valid,
  input logic [HS_W-1:0]  hs_code,
  input logic             locked
);
  AST_SETUP_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_CONTROL && ev_setup) |=> (bus_rdata == SETUP_WORD)); // R4

  AST_OUT_FULL_NAK: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && !tok_in && bus_rdata[B_OUTFULL] && !bus_rdata[B_STALLRQ])
      |=> (hs_valid && hs_code == HS_NAK)); // R5

  AST_STALL_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && bus_rdata[B_STALLRQ] && !ev_setup)
      |=> (hs_code == HS_STALL && bus_rdata[B_STALLED])); // R7

  AST_ACK_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ack && !ev_setup) |=> !bus_rdata[B_INRDY]); // R6

  AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid |=> hs_valid); // R5

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !tok_valid |=> !hs_valid); // R5

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && locked && !ev_setup && !ev_ack && !ev_out_ok && !tok_valid)
      |=> (bus_rdata == $past(bus_rdata))); // R8
endmodule

bind usb_ep_csr usb_ep_csr_chk #(.IS_CONTROL(IS_CONTROL)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .tok_valid (tok_valid),
  .tok_in    (tok_in),
  .ev_setup  (ev_setup),
  .ev_out_ok (ev_out_ok),
  .ev_ack    (ev_ack),
  .bus_rdata (bus_rdata),
  .hs_valid  (hs_valid),
  .hs_code   (hs_code),
  .locked    (locked)
);

// File: tb/test_usb_ep_csr.sv
module test_usb_ep_csr;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [8:0] bus_wdata = '0;
  logic [4:0] irq_en = '0;
  logic       tok_valid = 1'b0;
  logic       tok_in = 1'b0;
  logic       ev_setup = 1'b0;
  logic       ev_out_ok = 1'b0;
  logic       ev_ack = 1'b0;

  logic [8:0] rdata, b_rdata;
  logic       irq, b_irq, hs_valid, b_hs_valid;
  logic [2:0] hs_code, b_hs_code;

  localparam logic [2:0] ACK = 3'd0, NAK = 3'd1, STALL = 3'd2, DATA = 3'd3, ZLP = 3'd4;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  usb_ep_csr #(.IS_CONTROL(1'b1)) i_usb_ep_csr (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(rdata),
    .irq_en(irq_en), .irq(irq), .tok_valid(tok_valid), .tok_in(tok_in),
    .ev_setup(ev_setup), .ev_out_ok(ev_out_ok), .ev_ack(ev_ack),
    .hs_valid(hs_valid), .hs_code(hs_code)
  );

  usb_ep_csr #(.IS_CONTROL(1'b0)) i_usb_ep_csr_blk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(b_rdata),
    .irq_en(irq_en), .irq(b_irq), .tok_valid(tok_valid), .tok_in(tok_in),
    .ev_setup(ev_setup), .ev_out_ok(ev_out_ok), .ev_ack(ev_ack),
    .hs_valid(b_hs_valid), .hs_code(b_hs_code)
  );

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic write(input logic [8:0] d);
    bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic setup_pulse;
    ev_setup = 1'b1; @(negedge clk); ev_setup = 1'b0;
  endtask

  task automatic ack_pulse;
    ev_ack = 1'b1; @(negedge clk); ev_ack = 1'b0;
  endtask

  task automatic out_pulse;
    ev_out_ok = 1'b1; @(negedge clk); ev_out_ok = 1'b0;
  endtask

  task automatic token(input logic is_in);
    tok_valid = 1'b1; tok_in = is_in;
    @(negedge clk);
    tok_valid = 1'b0; tok_in = 1'b0;
  endtask

  task automatic t_reset;
    do_reset();
    check("R1 word after reset", rdata, 9'h000);
    check("R1 hs_valid after reset", {8'd0, hs_valid}, 9'h000);
    check("R1 irq with zero mask", {8'd0, irq}, 9'h000);
  endtask

  task automatic t_write;
    write(9'h1E0);
    check("R2 software bits written", rdata, 9'h1E0);
    write(9'h000);
    check("R2 software bits cleared", rdata, 9'h000);
    out_pulse();
    write(9'h002);
    check("R2 hw bit kept by writing 1", rdata, 9'h002);
    write(9'h000);
    check("R2 hw bit cleared by writing 0", rdata, 9'h000);
  endtask

  task automatic t_collide;
    bus_wr = 1'b1; bus_wdata = 9'h000; ev_out_ok = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; ev_out_ok = 1'b0;
    check("R3 hw set beats write clear", rdata, 9'h002);
    write(9'h000);
  endtask

  task automatic t_setup;
    write(9'h1E0);
    out_pulse();
    check("R4 word before setup", rdata, 9'h1E2);
    bus_wr = 1'b1; bus_wdata = 9'h0E0; ev_setup = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0; ev_setup = 1'b0;
    check("R4 setup wipes word despite write", rdata, 9'h004);
    write(9'h000);
  endtask

  task automatic t_out;
    token(1'b0);
    check("R5 OUT without wr_en is NAK", {6'd0, hs_code}, {6'd0, NAK});
    write(9'h080);
    token(1'b0);
    check("R5 OUT with wr_en is ACK", {6'd0, hs_code}, {6'd0, ACK});
    out_pulse();
    check("R5 out_full set", rdata, 9'h082);
    token(1'b0);
    check("R5 OUT while full is NAK", {6'd0, hs_code}, {6'd0, NAK});
    write(9'h080);
    token(1'b0);
    check("R5 OUT after drain is ACK", {6'd0, hs_code}, {6'd0, ACK});
    setup_pulse();
    write(9'h084);
    token(1'b0);
    check("R5 OUT while setup_seen is NAK", {6'd0, hs_code}, {6'd0, NAK});
    write(9'h000);
  endtask

  task automatic t_in;
    token(1'b1);
    check("R6 IN without data is NAK", {6'd0, hs_code}, {6'd0, NAK});
    check("R6 handshake valid", {8'd0, hs_valid}, 9'h001);
    write(9'h040);
    token(1'b1);
    check("R6 IN with data is DATA", {6'd0, hs_code}, {6'd0, DATA});
    ack_pulse();
    check("R6 ack clears in_ready", rdata, 9'h000);
  endtask

  task automatic t_stall;
    write(9'h020);
    token(1'b1);
    check("R7 IN under stall", {6'd0, hs_code}, {6'd0, STALL});
    check("R7 stalled set", rdata, 9'h028);
    token(1'b0);
    check("R7 OUT under stall", {6'd0, hs_code}, {6'd0, STALL});
    write(9'h000);
    check("R7 cleared", rdata, 9'h000);
  endtask

  task automatic t_ctrl_read;
    setup_pulse();
    write(9'h100);
    write(9'h140);
    token(1'b1);
    check("R9 first data packet", {6'd0, hs_code}, {6'd0, DATA});
    ack_pulse();
    check("R9 mid-stage ack no tx_done", rdata, 9'h100);
    write(9'h140);
    write(9'h150);
    write(9'h000);
    check("R8 write ignored while status pending", rdata, 9'h150);
    token(1'b1);
    check("R9 last data packet", {6'd0, hs_code}, {6'd0, DATA});
    ack_pulse();
    check("R9 last ack sets tx_done", rdata, 9'h111);
    token(1'b1);
    check("R9 IN in read status is NAK", {6'd0, hs_code}, {6'd0, NAK});
    token(1'b0);
    check("R9 status OUT ACK without wr_en", {6'd0, hs_code}, {6'd0, ACK});
    out_pulse();
    check("R9 status done keeps last_data", rdata, 9'h113);
    write(9'h000);
    check("R9 writable after status", rdata, 9'h000);
  endtask

  task automatic t_ctrl_write;
    setup_pulse();
    write(9'h080);
    token(1'b0);
    check("R10 data OUT accepted", {6'd0, hs_code}, {6'd0, ACK});
    out_pulse();
    write(9'h080);
    write(9'h090);
    check("R10 status pending word", rdata, 9'h090);
    token(1'b1);
    check("R10 status IN gets ZLP", {6'd0, hs_code}, {6'd0, ZLP});
    ack_pulse();
    check("R10 zlp ack sets tx_done", rdata, 9'h091);
    write(9'h000);
    setup_pulse();
    write(9'h010);
    token(1'b1);
    check("R10 no-data status ZLP", {6'd0, hs_code}, {6'd0, ZLP});
    ack_pulse();
    check("R10 no-data tx_done", rdata, 9'h011);
    write(9'h000);
  endtask

  task automatic t_irq;
    irq_en = 5'h10;
    @(negedge clk);
    check("R11 in_ready clear source", {8'd0, irq}, 9'h001);
    irq_en = 5'h02;
    @(negedge clk);
    check("R11 masked quiet", {8'd0, irq}, 9'h000);
    out_pulse();
    check("R11 out_full source", {8'd0, irq}, 9'h001);
    write(9'h000);
    check("R11 cleared source", {8'd0, irq}, 9'h000);
    irq_en = 5'h00;
  endtask

  task automatic t_bulk;
    do_reset();
    write(9'h1FF);
    check("R12 control-only bits read 0", b_rdata, 9'h060);
    setup_pulse();
    check("R12 setup ignored", b_rdata, 9'h060);
    write(9'h040);
    token(1'b0);
    check("R12 OUT ACK without wr_en", {6'd0, b_hs_code}, {6'd0, ACK});
    token(1'b1);
    check("R12 IN DATA", {6'd0, b_hs_code}, {6'd0, DATA});
    write(9'h050);
    write(9'h000);
    check("R12 last_data does not lock", b_rdata, 9'h000);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_write();
    t_collide();
    t_setup();
    t_out();
    t_in();
    t_stall();
    t_ctrl_read();
    t_ctrl_write();
    t_irq();
    t_bulk();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule